// File: doc/BRIEF.md
# Four-Channel Low-Side Driver Diagnostic Controller

This block holds the digital control and fault reporting for four low-side valve drivers. A common enable and one command input per channel decide when each channel's gate drive is on. The analog side supplies comparator results as flags, one set per channel:
- output voltage below the open-load level
- load current below the open-load current level
- load current above the overload level
- flyback clamp active
- over-temperature trip and release

It also supplies one bypass mismatch flag for each pair of channels.

From these flags the block drives a gate-enable and an active-low diagnostic line for every channel. It contains the fault latches, the two per-channel delay counters and the channel pairing used for bypass checks. Channel i is paired with channel NCH-1-i, so with four channels the pairs are 0/3 and 1/2.

Top module: `lsd_diag_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every latch and counter clears; with `en` low after reset, `gate` and `diag_n` are all zero.
- R2: With no fault, `gate[i]` equals `en & cmd[i]` in the same cycle. A low or unconnected control pin keeps the channel off.
- R3: With no fault, `diag_n[i]` equals `en`. With `en` low, every `diag_n` bit is 0.
- R4: With `en` high and `cmd[i]` low, `vlow[i]` high (and no clamp masking) drives `diag_n[i]` low in the same cycle. `vlow` has no effect on a channel that is on.
- R5: When a channel is on and `ilow[i]` has been high at OL_DLY consecutive clock edges, `diag_n[i]` goes low. It returns high in the same cycle that `ilow[i]` drops.
- R6: When a channel is on and `iover[i]` is high at OC_DLY consecutive edges, an overload latch sets at the last of them. `gate[i]` and `diag_n[i]` are then low. The latch holds until an edge sees `cmd[i]` low.
- R7: An edge with `ot_trip[i]` high turns `gate[i]` off and holds `diag_n[i]` low until an edge sees `cmd[i]` low.
- R8: After a trip, `gate[i]` stays off until an edge sees `ot_rel[i]` high, even when `cmd[i]` is toggled.
- R9: Bit p of `byp_mis` reports on both channels p and NCH-1-p (`diag_n` low) while `en` is high and both channels of the pair are commanded off.
- R10: A high `clamp[i]` masks the R4 check in that cycle and sets a disarm latch. The latch clears at the first edge that sees `cmd[i]` or `en` low with `clamp[i]` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Common enable |
| cmd | input | NCH | Per-channel on command |
| vlow | input | NCH | Output voltage below open-load level |
| ilow | input | NCH | Load current below open-load level |
| iover | input | NCH | Load current above overload level |
| clamp | input | NCH | Flyback clamp reached |
| ot_trip | input | NCH | Over-temperature trip |
| ot_rel | input | NCH | Over-temperature release |
| byp_mis | input | NCH/2 | Bypass mismatch, one per channel pair |
| gate | output | NCH | Gate enable per channel |
| diag_n | output | NCH | Diagnostic, low on fault or when disabled |

## Verification
The combinational responses in R2, R3, R4, R9 and the drop in R5 appear in the same cycle as the input change. The bench samples these one time unit after driving the inputs.

The latched results appear just after a specific clock edge:
- R6 and R7 show after the edge that sets their latch.
- The R5 flag shows after OL_DLY edges, and the R6 shutoff after OC_DLY edges.
- The R10 latch clears at the edge after the clamp drops.

The bench advances exactly that many edges and then checks one step past the edge. For the delays it also checks the edge before, to confirm the output has not moved early.

// File: rtl/lsd_diag_ctrl.sv
module lsd_diag_ctrl #(
  parameter int NCH    = 4,
  parameter int OL_DLY = 4,
  parameter int OC_DLY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [NCH-1:0]   cmd,
  input  logic [NCH-1:0]   vlow,
  input  logic [NCH-1:0]   ilow,
  input  logic [NCH-1:0]   iover,
  input  logic [NCH-1:0]   clamp,
  input  logic [NCH-1:0]   ot_trip,
  input  logic [NCH-1:0]   ot_rel,
  input  logic [NCH/2-1:0] byp_mis,
  output logic [NCH-1:0]   gate,
  output logic [NCH-1:0]   diag_n
);
  localparam int OLW = $clog2(OL_DLY + 1);
  localparam int OCW = $clog2(OC_DLY + 1);

  logic [NCH-1:0] on_cmd;
  assign on_cmd = {NCH{en}} & cmd;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int P = (i < NCH - 1 - i) ? i : NCH - 1 - i;
    localparam int M = NCH - 1 - i;

    logic           oc_lat, ot_lat, ot_hot, clp_lat;
    logic [OCW-1:0] oc_cnt;
    logic [OLW-1:0] ol_cnt;
    logic           oc_cond, ol_cond, ol_on, v_flt, b_flt;

    assign gate[i]  = on_cmd[i] & ~oc_lat & ~ot_lat & ~ot_hot;
    assign oc_cond  = gate[i] & iover[i];
    assign ol_cond  = gate[i] & ilow[i];
    assign ol_on    = ol_cond & (ol_cnt == OLW'(OL_DLY));
    assign v_flt    = en & ~cmd[i] & vlow[i] & ~clamp[i] & ~clp_lat;
    assign b_flt    = en & ~cmd[i] & ~cmd[M] & byp_mis[P];
    assign diag_n[i] = en & ~oc_lat & ~ot_lat & ~v_flt & ~ol_on & ~b_flt;

    always_ff @(posedge clk) begin
      if (rst) begin
        oc_lat  <= 1'b0;
        ot_lat  <= 1'b0;
        ot_hot  <= 1'b0;
        clp_lat <= 1'b0;
        oc_cnt  <= '0;
        ol_cnt  <= '0;
      end else begin
        oc_lat  <= (oc_cond && oc_cnt == OCW'(OC_DLY - 1)) || (oc_lat && cmd[i]);
        ot_lat  <= ot_trip[i] || (ot_lat && cmd[i]);
        ot_hot  <= ot_trip[i] || (ot_hot && !ot_rel[i]);
        clp_lat <= clamp[i] || (clp_lat && on_cmd[i]);
        if (!oc_cond)                      oc_cnt <= '0;
        else if (oc_cnt != OCW'(OC_DLY))   oc_cnt <= oc_cnt + 1'b1;
        if (!ol_cond)                      ol_cnt <= '0;
        else if (ol_cnt != OLW'(OL_DLY))   ol_cnt <= ol_cnt + 1'b1;
      end
    end
  end
endmodule

module lsd_diag_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [NCH-1:0]   cmd,
  input logic [NCH-1:0]   iover,
  input logic [NCH-1:0]   ot_trip,
  input logic [NCH/2-1:0] byp_mis,
  input logic [NCH-1:0]   gate,
  input logic [NCH-1:0]   diag_n
);
  a_r2_gate_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    (gate & ~({NCH{en}} & cmd)) == '0);

  a_r3_diag_low_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |-> diag_n == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    localparam int P = (i < NCH - 1 - i) ? i : NCH - 1 - i;
    localparam int M = NCH - 1 - i;

    a_r6_gate_drop_has_cause: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(gate[i]) && !gate[i] && en && cmd[i] && $past(en && cmd[i]))
      |-> $past(iover[i] || ot_trip[i]));

    a_r7_trip_turns_off: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ot_trip[i])) |-> !gate[i] && !diag_n[i]);

    a_r9_bypass_reported: assert property (@(posedge clk) disable iff (rst)
      (en && byp_mis[P] && !cmd[i] && !cmd[M]) |-> !diag_n[i]);
  end
endmodule

bind lsd_diag_ctrl lsd_diag_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cmd(cmd), .iover(iover), .ot_trip(ot_trip),
  .byp_mis(byp_mis), .gate(gate), .diag_n(diag_n)
);

// File: tb/tb_lsd_diag_ctrl.sv
module tb_lsd_diag_ctrl;
  localparam int NCH = 4, OL_DLY = 4, OC_DLY = 3;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [3:0] cmd = '0, vlow = '0, ilow = '0, iover = '0, clamp = '0, ot_trip = '0, ot_rel = '0;
  logic [1:0] byp_mis = '0;
  logic [3:0] gate, diag_n;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lsd_diag_ctrl #(.NCH(NCH), .OL_DLY(OL_DLY), .OC_DLY(OC_DLY)) dut (
    .clk(clk), .rst(rst), .en(en), .cmd(cmd), .vlow(vlow), .ilow(ilow), .iover(iover),
    .clamp(clamp), .ot_trip(ot_trip), .ot_rel(ot_rel), .byp_mis(byp_mis),
    .gate(gate), .diag_n(diag_n));

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  initial begin
    tick(2);
    rst = 1'b0;
    #1;
    chk("R1", "gate after reset", gate, 4'b0000);
    chk("R1", "diag after reset", diag_n, 4'b0000);

    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 16; c++) begin
        en = e[0];
        cmd = c[3:0];
        #1;
        chk("R2", "gate sweep", gate, {4{e[0]}} & c[3:0]);
        chk("R3", "diag sweep", diag_n, {4{e[0]}});
      end

    en = 1'b1; cmd = '0;
    for (int v = 0; v < 16; v++) begin
      vlow = v[3:0];
      #1;
      chk("R4", "vlow off", diag_n, ~v[3:0]);
    end
    cmd = 4'hF; vlow = 4'hF; #1;
    chk("R4", "vlow while on", diag_n, 4'hF);
    en = 1'b0; #1;
    chk("R4", "vlow disabled", diag_n, 4'h0);
    en = 1'b1; cmd = '0; vlow = '0; tick();

    cmd = 4'b0001; ilow = 4'b0001; #1;
    tick(OL_DLY - 1);
    chk("R5", "before delay", diag_n, 4'hF);
    tick();
    chk("R5", "after delay", diag_n, 4'b1110);
    chk("R5", "gate kept", gate, 4'b0001);
    ilow = '0; #1;
    chk("R5", "clear", diag_n, 4'hF);
    cmd = '0; tick();

    cmd = 4'b0010; iover = 4'b0010; #1;
    tick(OC_DLY - 1);
    chk("R6", "gate before delay", gate, 4'b0010);
    tick();
    chk("R6", "gate tripped", gate, 4'b0000);
    chk("R6", "diag tripped", diag_n, 4'b1101);
    iover = '0; tick();
    chk("R6", "latched", gate, 4'b0000);
    cmd = '0; tick();
    chk("R6", "cleared diag", diag_n, 4'hF);
    cmd = 4'b0010; #1;
    chk("R6", "gate restored", gate, 4'b0010);
    cmd = '0; tick();

    cmd = 4'b0100; ot_trip = 4'b0100; tick(); ot_trip = '0; #1;
    chk("R7", "gate off", gate, 4'b0000);
    chk("R7", "diag low", diag_n, 4'b1011);
    ot_rel = 4'b0100; tick(); ot_rel = '0; #1;
    chk("R7", "held while cmd high", diag_n, 4'b1011);
    cmd = '0; tick();
    chk("R7", "cleared on cmd low", diag_n, 4'hF);
    cmd = 4'b0100; #1;
    chk("R7", "gate back", gate, 4'b0100);

    ot_trip = 4'b0100; tick(); ot_trip = '0;
    cmd = '0; tick(); cmd = 4'b0100; tick();
    chk("R8", "still hot", gate, 4'b0000);
    chk("R8", "diag after cmd cycle", diag_n, 4'hF);
    ot_rel = 4'b0100; tick(); ot_rel = '0; #1;
    chk("R8", "released", gate, 4'b0100);
    cmd = '0; tick();

    byp_mis = 2'b01; #1;
    chk("R9", "pair 0/3", diag_n, 4'b0110);
    cmd = 4'b0001; #1;
    chk("R9", "pair 0/3 one on", diag_n, 4'hF);
    cmd = '0; byp_mis = 2'b10; #1;
    chk("R9", "pair 1/2", diag_n, 4'b1001);
    byp_mis = '0; tick();

    vlow = 4'b1000; clamp = 4'b1000; #1;
    chk("R10", "masked by clamp", diag_n, 4'hF);
    tick(); clamp = '0; #1;
    chk("R10", "disarm latched", diag_n, 4'hF);
    tick();
    chk("R10", "rearmed", diag_n, 4'b0111);
    vlow = '0; tick();

    cmd = 4'b0001; iover = 4'b0001; tick(OC_DLY);
    chk("R1", "overload set", gate, 4'b0000);
    iover = '0; rst = 1'b1; tick(); rst = 1'b0; #1;
    chk("R1", "reset clears latch", gate, 4'b0001);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule